// File: doc/BRIEF.md
# DRAM node range decoder

The decoder maps a physical system address onto the memory node that owns it. Software loads a small table through a plain write port. The table holds one base/limit window per node, an optional node-interleave rule per window, a hole window below 4 GiB for memory-mapped I/O, and a low-memory region swap. Addresses enter on a valid/ready stream, one per accepted beat. The result leaves one cycle later on a second valid/ready stream. It carries the owning node, a hit flag, an out-of-bounds flag, a configuration-error flag, the interleave log2 and the node-relative address. Channel and rank selection take this result as input.

Flow control follows these rules. `in_ready` equals `!out_valid || out_ready`, so a new address is accepted whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every result field stays frozen. Configuration writes take effect at the clock edge that captures them. An address accepted on that same edge is decoded against the table as it stood before the write.

Top module: `node_range_dec`

## Requirements
- R1: Window r takes its enable field from bits [1:0] of config word 4r. While that field is zero the window never matches, even if the address lies inside it.
- R2: Window r's base is {word 4r+1 bits [7:0], word 4r bits [31:16], 24 zero bits}. Its limit is {word 4r+3 bits [7:0], word 4r+2 bits [31:16], 24 one bits}. Both bounds are inclusive.
- R3: The interleave mask is word 4r bits [10:8] and the interleave select is word 4r+2 bits [10:8]. A window matches only when the mask is zero or the select equals address bits [14:12] ANDed with the mask.
- R4: When several windows match, the lowest index wins. The reported node is word 4r+2 bits [2:0] of the winning window.
- R5: Interleave masks 0, 1, 3 and 7 give an interleave log2 of 0, 1, 2 and 3. Any other mask on the winning window raises `out_cfg_err` and `out_oob` and clears `out_hit`.
- R6: Hole word 4N (N windows) holds a valid bit at bit 0 and the hole base in 16 MiB units at bits [15:8]. A matched address at or above the hole base and below 4 GiB gives `out_oob`=1 and `out_hit`=0, and the node is still reported.
- R7: Swap word 4N+1 holds enable at bit 0, base at [14:8], limit at [22:16] and size at [30:24], all in 128 MiB units. The swap applies when it is enabled, address bits [47:34] are zero, and the index (address bits [33:27]) is either inside [base, limit] or below size. The address is then XORed with base << 27 before normalisation.
- R8: On a hit, `out_naddr` is the (possibly swapped) address shifted right by 12 + log2, shifted left by 12, with its original low 12 bits kept.
- R9: When no window matches, the outputs are `out_oob`=1, `out_hit`=0, `out_cfg_err`=0, node 0, log2 0 and normalised address 0.
- R10: Outputs appear one cycle after acceptance, `in_ready` is `!out_valid || out_ready`, and all outputs hold while `out_valid && !out_ready`.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, and the table is cleared, so every address is out of bounds.
- R12: `hole_ofs` continuously shows hole word bits [24:16], the hole offset in 8 MiB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW (6) | Config word index |
| cfg_wdata | input | 32 | Config write data |
| in_valid | input | 1 | Address beat valid |
| in_ready | output | 1 | Address beat accepted when high with valid |
| in_addr | input | 48 | System physical address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_hit | output | 1 | Address decoded to DRAM |
| out_oob | output | 1 | Address out of bounds |
| out_cfg_err | output | 1 | Winning window has an illegal interleave mask |
| out_node | output | 3 | Owning node |
| out_ilog | output | 2 | Node interleave log2 |
| out_naddr | output | 48 | Node-relative address |
| hole_ofs | output | 9 | Hole offset, 8 MiB units |

## Verification
The hardest case to reach is a swap remap that lands on an address which is also node-interleaved and is held under back-pressure. The swap only touches addresses below 16 GiB, and the stripped bits depend on the winning window's mask. To reach it, the stimulus programs overlapping windows, interleaved pairs, an illegal-mask window and a window above 1 TiB. It then turns the swap on mid-run and sends directed addresses on every edge of these windows. Finally it sends several hundred addresses drawn from around each window while `out_ready` is dropped at random. A behavioural model in the bench predicts every cycle's outputs from the words it wrote.

// File: rtl/ndec_pkg.sv
package ndec_pkg;
  localparam int PA_W   = 48;
  localparam int NODE_W = 3;

  typedef struct packed {
    logic [1:0]  en;
    logic [2:0]  imask;
    logic [15:0] base;
    logic [7:0]  base_hi;
    logic [NODE_W-1:0] node;
    logic [2:0]  isel;
    logic [15:0] lim;
    logic [7:0]  lim_hi;
  } win_cfg_t;

  typedef struct packed {
    logic        hole_v;
    logic [7:0]  hole_base;
    logic [8:0]  hole_ofs;
    logic        sw_en;
    logic [6:0]  sw_base;
    logic [6:0]  sw_lim;
    logic [6:0]  sw_size;
  } glob_cfg_t;

  typedef struct packed {
    logic        hit;
    logic        oob;
    logic        err;
    logic [NODE_W-1:0] node;
    logic [1:0]  ilog;
    logic [PA_W-1:0] naddr;
  } dec_res_t;
endpackage

// File: rtl/ndec_cfg_regs.sv
module ndec_cfg_regs
  import ndec_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  output win_cfg_t      wcfg [N],
  output glob_cfg_t     gcfg
);
  localparam logic [AW-1:0] HOLE_A = AW'(N * 4);
  localparam logic [AW-1:0] SWAP_A = AW'(N * 4 + 1);

  for (genvar g = 0; g < N; g++) begin : g_win
    localparam logic [AW-1:0] A0 = AW'(g * 4);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wcfg[g] <= '0;
      end else if (we) begin
        if (waddr == A0) begin
          wcfg[g].en    <= wdata[1:0];
          wcfg[g].imask <= wdata[10:8];
          wcfg[g].base  <= wdata[31:16];
        end
        if (waddr == A0 + AW'(1)) wcfg[g].base_hi <= wdata[7:0];
        if (waddr == A0 + AW'(2)) begin
          wcfg[g].node <= wdata[NODE_W-1:0];
          wcfg[g].isel <= wdata[10:8];
          wcfg[g].lim  <= wdata[31:16];
        end
        if (waddr == A0 + AW'(3)) wcfg[g].lim_hi <= wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg <= '0;
    end else if (we) begin
      if (waddr == HOLE_A) begin
        gcfg.hole_v    <= wdata[0];
        gcfg.hole_base <= wdata[15:8];
        gcfg.hole_ofs  <= wdata[24:16];
      end
      if (waddr == SWAP_A) begin
        gcfg.sw_en   <= wdata[0];
        gcfg.sw_base <= wdata[14:8];
        gcfg.sw_lim  <= wdata[22:16];
        gcfg.sw_size <= wdata[30:24];
      end
    end
  end
endmodule

// File: rtl/ndec_range_match.sv
module ndec_range_match
  import ndec_pkg::*;
(
  input  logic [PA_W-1:0] addr,
  input  logic [1:0]      en,
  input  logic [2:0]      imask,
  input  logic [2:0]      isel,
  input  logic [15:0]     base,
  input  logic [7:0]      base_hi,
  input  logic [15:0]     lim,
  input  logic [7:0]      lim_hi,
  output logic            hit
);
  logic [PA_W-1:0] lo_bound, hi_bound;
  logic            in_win, il_ok;

  always_comb begin
    lo_bound = {base_hi, base, 24'h00_0000};
    hi_bound = {lim_hi, lim, 24'hFF_FFFF};
    in_win   = (addr >= lo_bound) && (addr <= hi_bound);
    il_ok    = (imask == 3'd0) || (isel == (addr[14:12] & imask));
    hit      = (en != 2'd0) && in_win && il_ok;
  end
endmodule

// File: rtl/ndec_pick.sv
module ndec_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hit_vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] gnt;

  always_comb begin
    any = 1'b0;
    idx = '0;
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any    = 1'b1;
        idx    = IW'(i);
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (any == (hit_vec != '0)));

  assert_grant_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (((hit_vec & (gnt - N'(1))) == '0) && ((hit_vec & gnt) != '0)));
endmodule

// File: rtl/ndec_norm.sv
module ndec_norm
  import ndec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   addr,
  input  logic              any,
  input  logic [2:0]        imask,
  input  logic [NODE_W-1:0] node,
  input  logic              hole_v,
  input  logic [7:0]        hole_base,
  input  logic              sw_en,
  input  logic [6:0]        sw_base,
  input  logic [6:0]        sw_lim,
  input  logic [6:0]        sw_size,
  output dec_res_t          res
);
  logic [1:0]      ilog;
  logic            bad_mask, in_hole, swap_hit, oob;
  logic [6:0]      blk;
  logic [PA_W-1:0] swp, shr;

  always_comb begin
    bad_mask = 1'b0;
    case (imask)
      3'd0:    ilog = 2'd0;
      3'd1:    ilog = 2'd1;
      3'd3:    ilog = 2'd2;
      3'd7:    ilog = 2'd3;
      default: begin ilog = 2'd0; bad_mask = 1'b1; end
    endcase

    in_hole  = hole_v && (addr[PA_W-1:32] == '0) && (addr[31:24] >= hole_base);

    blk      = addr[33:27];
    swap_hit = sw_en && (addr[PA_W-1:34] == '0) &&
               (((blk >= sw_base) && (blk <= sw_lim)) || (blk < sw_size));
    swp      = swap_hit ? (addr ^ {14'd0, sw_base, 27'd0}) : addr;
    shr      = swp >> ilog;

    oob       = !any || in_hole || bad_mask;
    res.hit   = !oob;
    res.oob   = oob;
    res.err   = any && bad_mask;
    res.node  = any ? node : '0;
    res.ilog  = oob ? 2'd0 : ilog;
    res.naddr = oob ? '0 : {shr[PA_W-1:12], swp[11:0]};
  end

  assert_hole_blocks_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hole_v && (addr < 48'h1_0000_0000) && (addr >= {16'd0, hole_base, 24'd0}))
      |-> (!res.hit && res.oob));

  assert_miss_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (res.oob && !res.err && (res.node == '0) && (res.naddr == '0)));

  assert_bad_mask_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any && (imask == 3'd2 || imask == 3'd4 || imask == 3'd5 || imask == 3'd6))
      |-> (res.err && !res.hit));
endmodule

// File: rtl/node_range_dec.sv
module node_range_dec
  import ndec_pkg::*;
#(
  parameter  int NUM_RANGES = 8,
  localparam int CFG_AW     = $clog2(NUM_RANGES * 4 + 2),
  localparam int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PA_W-1:0]   in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic              out_oob,
  output logic              out_cfg_err,
  output logic [NODE_W-1:0] out_node,
  output logic [1:0]        out_ilog,
  output logic [PA_W-1:0]   out_naddr,
  output logic [8:0]        hole_ofs
);
  win_cfg_t        wcfg [NUM_RANGES];
  glob_cfg_t       gcfg;
  logic [NUM_RANGES-1:0] hit_vec;
  logic            any;
  logic [IDX_W-1:0] win_idx;
  dec_res_t        res_d, res_q;
  logic            ov_q;
  logic [PA_W-1:0] addr_q;

  ndec_cfg_regs #(.N(NUM_RANGES), .AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .wcfg(wcfg), .gcfg(gcfg)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    ndec_range_match u_match (
      .addr(in_addr), .en(wcfg[g].en), .imask(wcfg[g].imask),
      .isel(wcfg[g].isel), .base(wcfg[g].base), .base_hi(wcfg[g].base_hi),
      .lim(wcfg[g].lim), .lim_hi(wcfg[g].lim_hi), .hit(hit_vec[g])
    );
  end

  ndec_pick #(.N(NUM_RANGES), .IW(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .any(any), .idx(win_idx)
  );

  ndec_norm u_norm (
    .clk(clk), .rst_n(rst_n), .addr(in_addr), .any(any),
    .imask(wcfg[win_idx].imask), .node(wcfg[win_idx].node),
    .hole_v(gcfg.hole_v), .hole_base(gcfg.hole_base),
    .sw_en(gcfg.sw_en), .sw_base(gcfg.sw_base), .sw_lim(gcfg.sw_lim),
    .sw_size(gcfg.sw_size), .res(res_d)
  );

  assign in_ready = !ov_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      res_q  <= '0;
      addr_q <= '0;
    end else if (in_valid && in_ready) begin
      ov_q   <= 1'b1;
      res_q  <= res_d;
      addr_q <= in_addr;
    end else if (out_ready) begin
      ov_q   <= 1'b0;
    end
  end

  assign out_valid   = ov_q;
  assign out_hit     = res_q.hit;
  assign out_oob     = res_q.oob;
  assign out_cfg_err = res_q.err;
  assign out_node    = res_q.node;
  assign out_ilog    = res_q.ilog;
  assign out_naddr   = res_q.naddr;
  assign hole_ofs    = gcfg.hole_ofs;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_naddr) &&
      $stable(out_node) && $stable(out_hit) && $stable(out_oob) && $stable(out_ilog)));

  assert_accept_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_low_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (out_naddr[11:0] == addr_q[11:0]));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_oob));
endmodule

// File: tb/node_range_dec_tb.sv
`timescale 1ns/1ps
module node_range_dec_tb;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit, out_oob, out_cfg_err;
  logic [2:0]  out_node;
  logic [1:0]  out_ilog;
  logic [47:0] out_naddr;
  logic [8:0]  hole_ofs;

  always #4 clk = ~clk;

  node_range_dec #(.NUM_RANGES(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_oob(out_oob), .out_cfg_err(out_cfg_err),
    .out_node(out_node), .out_ilog(out_ilog), .out_naddr(out_naddr),
    .hole_ofs(hole_ofs)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit stall_en = 0;
  string cur_tag = "R11";

  // shadow of written words
  logic [31:0] sh_w [NR*4+2];

  // model state
  bit          m_valid = 0;
  bit          m_acc = 0;
  logic        e_hit, e_oob, e_err;
  logic [2:0]  e_node;
  logic [1:0]  e_ilog;
  logic [47:0] e_naddr;
  string       e_tag;

  task automatic model_decode(input logic [47:0] a,
      output logic hit, output logic oob, output logic err,
      output logic [2:0] node, output logic [1:0] ilog, output logic [47:0] na);
    int w = -1;
    int k = 0;
    logic [47:0] s, b, l;
    logic [2:0] mask, sel;
    logic in_hole, sw;
    int blk, sb, slim, ssz;
    for (int r = 0; r < NR; r++) begin
      b = {sh_w[4*r+1][7:0], sh_w[4*r][31:16], 24'h0};
      l = {sh_w[4*r+3][7:0], sh_w[4*r+2][31:16], 24'hFFFFFF};
      mask = sh_w[4*r][10:8];
      sel  = sh_w[4*r+2][10:8];
      if (w < 0 && sh_w[4*r][1:0] != 0 && a >= b && a <= l &&
          (mask == 0 || sel == (a[14:12] & mask))) w = r;
    end
    hit = 0; oob = 1; err = 0; node = 0; ilog = 0; na = 0;
    if (w >= 0) begin
      node = sh_w[4*w+2][2:0];
      mask = sh_w[4*w][10:8];
      if (mask == 0) k = 0; else if (mask == 1) k = 1;
      else if (mask == 3) k = 2; else if (mask == 7) k = 3;
      else err = 1;
      in_hole = sh_w[4*NR][0] && a >= {16'h0, sh_w[4*NR][15:8], 24'h0} &&
                a < 48'h1_0000_0000;
      if (!err && !in_hole) begin
        blk = int'(a[33:27]);
        sb = int'(sh_w[4*NR+1][14:8]);
        slim = int'(sh_w[4*NR+1][22:16]);
        ssz = int'(sh_w[4*NR+1][30:24]);
        sw = sh_w[4*NR+1][0] && a < 48'h4_0000_0000 &&
             ((blk >= sb && blk <= slim) || blk < ssz);
        s = sw ? (a ^ (48'(sb) << 27)) : a;
        na = ((s >> (12 + k)) << 12) | {36'h0, s[11:0]};
        hit = 1; oob = 0; ilog = 2'(k);
      end
    end
  endtask

  always @(posedge clk) begin
    bit rdy;
    m_acc = 0;
    if (!rst_n) begin
      m_valid = 0;
      for (int i = 0; i < NR*4+2; i++) sh_w[i] = '0;
    end else begin
      rdy = !m_valid || out_ready;
      if (in_valid && rdy) begin
        model_decode(in_addr, e_hit, e_oob, e_err, e_node, e_ilog, e_naddr);
        e_tag = cur_tag;
        m_valid = 1;
        m_acc = 1;
      end else if (out_ready) begin
        m_valid = 0;
      end
      if (cfg_we) sh_w[cfg_addr] = cfg_wdata;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      total++;
      if (out_valid !== m_valid) begin
        bad++;
        $display("FAIL R10 out_valid got=%0b exp=%0b", out_valid, m_valid);
      end else if (m_valid) begin
        total++;
        if ({out_hit, out_oob, out_cfg_err, out_node, out_ilog, out_naddr} !==
            {e_hit, e_oob, e_err, e_node, e_ilog, e_naddr}) begin
          bad++;
          $display("FAIL %s got hit=%0b oob=%0b err=%0b node=%0d ilog=%0d naddr=%h exp hit=%0b oob=%0b err=%0b node=%0d ilog=%0d naddr=%h",
            e_tag, out_hit, out_oob, out_cfg_err, out_node, out_ilog, out_naddr,
            e_hit, e_oob, e_err, e_node, e_ilog, e_naddr);
        end
      end
    end
  end

  always @(negedge clk) out_ready <= stall_en ? ($urandom % 3 != 0) : 1'b1;

  task automatic cfg_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [47:0] a, input string tag);
    @(negedge clk);
    in_valid = 1; in_addr = a; cur_tag = tag;
    forever begin
      @(posedge clk); #1;
      if (m_acc) break;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check_eq(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic win(input int r, input logic [15:0] b, input logic [7:0] bh,
                     input logic [15:0] l, input logic [7:0] lh,
                     input logic [1:0] en, input logic [2:0] mask,
                     input logic [2:0] sel, input logic [2:0] node);
    cfg_write(4*r,   {b, 5'd0, mask, 6'd0, en});
    cfg_write(4*r+1, {24'd0, bh});
    cfg_write(4*r+2, {l, 5'd0, sel, 5'd0, node});
    cfg_write(4*r+3, {24'd0, lh});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R11 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check_eq("R11 in_ready after reset", {63'd0, in_ready}, 64'd1);
    check_eq("R12 hole_ofs after reset", {55'd0, hole_ofs}, 64'd0);
    send(48'h0000_0000_1000, "R11");

    // windows
    win(0, 16'h0000, 8'h00, 16'h00FF, 8'h00, 2'd3, 3'd0, 3'd0, 3'd0);
    win(1, 16'h0100, 8'h00, 16'h01FF, 8'h00, 2'd1, 3'd1, 3'd0, 3'd3);
    win(2, 16'h0100, 8'h00, 16'h01FF, 8'h00, 2'd2, 3'd1, 3'd1, 3'd6);
    win(3, 16'h0200, 8'h00, 16'h02FF, 8'h00, 2'd0, 3'd0, 3'd0, 3'd7);
    win(4, 16'h0200, 8'h00, 16'h02FF, 8'h00, 2'd1, 3'd3, 3'd2, 3'd1);
    win(5, 16'h0000, 8'h00, 16'h00FF, 8'h00, 2'd1, 3'd0, 3'd0, 3'd5);
    win(6, 16'h0000, 8'h01, 16'h00FF, 8'h01, 2'd1, 3'd2, 3'd0, 3'd4);
    win(7, 16'h0000, 8'h02, 16'h00FF, 8'h02, 2'd1, 3'd7, 3'd5, 3'd2);
    cfg_write(4*NR, {7'd0, 9'h1AB, 8'hC0, 7'd0, 1'b1});
    @(negedge clk);
    check_eq("R12 hole_ofs", {55'd0, hole_ofs}, 64'h1AB);

    send(48'h0000_1234_5678, "R4");
    send(48'h0000_BFFF_FFFF, "R6");
    send(48'h0000_C000_0000, "R6");
    send(48'h0000_FFFF_FFFF, "R6");
    send(48'h0001_0000_0000, "R2");
    send(48'h0001_0000_1ABC, "R3");
    send(48'h0001_FFFF_FFFF, "R2");
    send(48'h0002_0000_2000, "R5");
    send(48'h0002_0000_1000, "R1");
    send(48'h0003_0000_0000, "R9");
    send(48'h0100_0000_0000, "R5");
    send(48'h0200_0000_5ABC, "R8");
    send(48'h0200_FFFF_DFFF, "R2");
    send(48'h0201_0000_5000, "R9");

    cfg_write(4*NR+1, {1'b0, 7'd2, 1'b0, 7'd3, 1'b0, 7'd2, 7'd0, 1'b1});
    send(48'h0000_0000_1000, "R7");
    send(48'h0000_1800_0123, "R7");
    send(48'h0000_2000_0000, "R7");
    send(48'h0001_1000_3000, "R7");
    send(48'h0200_0000_5ABC, "R7");
    send(48'h0000_C000_0000, "R6");

    stall_en = 1;
    for (int i = 0; i < 400; i++) begin
      logic [47:0] a;
      int sel = $urandom % 6;
      logic [31:0] lo = $urandom;
      case (sel)
        0: a = {16'h0, lo};
        1: a = 48'h0001_0000_0000 + {16'h0, lo};
        2: a = 48'h0002_0000_0000 + {16'h0, lo};
        3: a = 48'h0100_0000_0000 + {16'h0, lo};
        4: a = 48'h0200_0000_0000 + {16'h0, lo};
        default: a = {16'($urandom), lo};
      endcase
      send(a, "R10");
    end
    stall_en = 0;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule